// File: doc/BRIEF.md
# Serial Max-Log LLR Unit

This block forms the soft decision for one information bit of a max-log soft-in/soft-out component decoder. Trellis states arrive one at a time, flagged by a state-slot strobe. Each state carries three metrics: the forward metric for an input-0 branch, the forward metric for an input-1 branch, and the backward metric of that state. The block adds each forward metric to the backward metric and keeps two running maxima with compare-select logic that runs at the state rate. When the last of the sixteen states of a bit has been seen, it subtracts the input-1 maximum from the input-0 maximum. That difference is the log-likelihood ratio, where a positive value favours a 0.

A second subtraction, also done once per bit, removes twice the systematic sample and twice the scaled a-priori value from the ratio. The result is the extrinsic value for the next component decoder. The a-priori scaling divides by a power of two, so it is an arithmetic right shift. In the final pipeline stage no further extrinsic value is needed, and that output is forced to zero. The metric memories that feed the block sit outside it.

Top module: `maxlog_llr_serial`

## Requirements
- R1: For each bit, `llr_out` equals the maximum over its 16 state slots of (`fwd0_in` + `bwd_in`) minus the maximum over the same slots of (`fwd1_in` + `bwd_in`), as a signed two's complement value with no loss of range.
- R2: A cycle counts as a state slot only when `slot_vld` is 1. Metric values presented while `slot_vld` is 0 have no effect on any output.
- R3: The running maxima restart at the first slot of every bit, so the metrics of an earlier bit have no effect on a later bit's result.
- R4: `hard_out` is 0 when the bit's LLR is zero or positive, and 1 when it is negative.
- R5: `ext_out` equals LLR − 2·`sys_in` − 2·floor(`apr_in` / 2^`q_shift`), saturated to the signed range of its width (−128..127 by default). `sys_in`, `apr_in` and `q_shift` are taken at the 16th slot.
- R6: When `last_stage` is 1 at the 16th slot of a bit, `ext_out` for that bit is 0.
- R7: `out_vld` is a single-cycle pulse in the cycle after the clock edge that takes the 16th slot of a bit. `llr_out`, `hard_out` and `ext_out` change only together with that pulse.
- R8: While `rst_n` is low, `out_vld`, `llr_out`, `hard_out` and `ext_out` are 0, and the slot count returns to the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | 1 | Marks a cycle that carries one state slot |
| fwd0_in | input | MW (10) | Signed forward metric, input-0 branch |
| fwd1_in | input | MW (10) | Signed forward metric, input-1 branch |
| bwd_in | input | MW (10) | Signed backward metric of the state |
| sys_in | input | SYW (6) | Signed systematic sample of the bit |
| apr_in | input | APW (8) | Signed a-priori value of the bit |
| q_shift | input | QW (2) | log2 of the a-priori divisor |
| last_stage | input | 1 | Disables the extrinsic subtraction (output 0) |
| llr_out | output | MW+2 (12) | Signed LLR of the last completed bit |
| hard_out | output | 1 | Hard decision of the last completed bit |
| ext_out | output | EW (8) | Signed, saturated extrinsic value |
| out_vld | output | 1 | One-cycle pulse marking new results |

## Verification
The hardest case to reach from the ports is a bit whose state slots are spread out by idle cycles. Those idle cycles carry metric values that would win the compare-select if they were counted, and they must not be counted. The bench breaks the strobe into several separate runs inside one bit and drives the largest legal metrics during the gaps, so any cycle counted by mistake changes the LLR. It also follows a bit with large metrics by a bit with small ones, which exposes a maximum that does not restart. Bits with opposite extreme metrics drive the extrinsic value into both saturation limits.

// File: rtl/llr_pkg.sv
package llr_pkg;
  // Position of the current state slot inside one bit period
  typedef struct packed {
    logic first;
    logic last;
  } slot_pos_t;
endpackage

// File: rtl/llr_slot_ctr.sv
module llr_slot_ctr
  import llr_pkg::*;
#(
  parameter int NSTATE = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slot_vld,
  output slot_pos_t pos
);
  localparam int CW = $clog2(NSTATE);
  localparam logic [CW-1:0] LAST_IDX = CW'(NSTATE - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (slot_vld) begin
      if (cnt_q == LAST_IDX) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pos.first = (cnt_q == '0);
  assign pos.last  = (cnt_q == LAST_IDX);
endmodule

// File: rtl/llr_max_track.sv
module llr_max_track #(
  parameter int MW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_vld,
  input  logic                 slot_first,
  input  logic signed [MW-1:0] fwd,
  input  logic signed [MW-1:0] bwd,
  output logic signed [MW:0]   cur_max
);
  localparam int SW = MW + 1;
  localparam logic signed [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

  logic signed [SW-1:0] sum, base, max_q, max_d;

  // Branch sum widened by one bit so it cannot wrap
  assign sum  = {fwd[MW-1], fwd} + {bwd[MW-1], bwd};
  // At the first slot the comparison starts from the most negative value
  assign base = slot_first ? MOST_NEG : max_q;
  assign cur_max = (sum > base) ? sum : base;

  always_comb begin
    max_d = max_q;
    if (slot_vld) max_d = cur_max;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) max_q <= MOST_NEG;
    else        max_q <= max_d;
  end
endmodule

// File: rtl/llr_bit_finish.sv
module llr_bit_finish #(
  parameter int SW  = 11,
  parameter int SYW = 6,
  parameter int APW = 8,
  parameter int QW  = 2,
  parameter int EW  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_done,
  input  logic signed [SW-1:0]  max0,
  input  logic signed [SW-1:0]  max1,
  input  logic signed [SYW-1:0] sys_in,
  input  logic signed [APW-1:0] apr_in,
  input  logic [QW-1:0]         q_shift,
  input  logic                  last_stage,
  output logic signed [SW:0]    llr_q,
  output logic                  hard_q,
  output logic signed [EW-1:0]  ext_q,
  output logic                  vld_q
);
  localparam int LW = SW + 1;
  localparam int XW = ((LW > APW) ? LW : APW) + 3;

  logic signed [LW-1:0]  llr_w;
  logic signed [APW-1:0] apr_sh;
  logic signed [XW-1:0]  llr_x, sys_x, apr_x, ext_x;
  logic signed [EW-1:0]  ext_sat, ext_w;
  logic                  fits;

  logic signed [LW-1:0] llr_d;
  logic                 hard_d;
  logic signed [EW-1:0] ext_d;

  assign llr_w  = {max0[SW-1], max0} - {max1[SW-1], max1};
  // Division by a power of two, rounding towards minus infinity
  assign apr_sh = apr_in >>> q_shift;

  assign llr_x = {{(XW-LW){llr_w[LW-1]}}, llr_w};
  assign sys_x = {{(XW-SYW){sys_in[SYW-1]}}, sys_in};
  assign apr_x = {{(XW-APW){apr_sh[APW-1]}}, apr_sh};
  assign ext_x = llr_x - (sys_x <<< 1) - (apr_x <<< 1);

  // The value fits when all bits above the output sign agree
  assign fits = (ext_x[XW-1:EW-1] == '0) || (ext_x[XW-1:EW-1] == '1);

  always_comb begin
    if (fits)              ext_sat = ext_x[EW-1:0];
    else if (ext_x[XW-1])  ext_sat = {1'b1, {(EW-1){1'b0}}};
    else                   ext_sat = {1'b0, {(EW-1){1'b1}}};
    ext_w = last_stage ? '0 : ext_sat;
  end

  always_comb begin
    llr_d  = llr_q;
    hard_d = hard_q;
    ext_d  = ext_q;
    if (bit_done) begin
      llr_d  = llr_w;
      hard_d = llr_w[LW-1];
      ext_d  = ext_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llr_q  <= '0;
      hard_q <= 1'b0;
      ext_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      llr_q  <= llr_d;
      hard_q <= hard_d;
      ext_q  <= ext_d;
      vld_q  <= bit_done;
    end
  end
endmodule

// File: rtl/maxlog_llr_serial.sv
module maxlog_llr_serial
  import llr_pkg::*;
#(
  parameter int NSTATE = 16,
  parameter int MW     = 10,
  parameter int SYW    = 6,
  parameter int APW    = 8,
  parameter int QW     = 2,
  parameter int EW     = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_vld,
  input  logic signed [MW-1:0]  fwd0_in,
  input  logic signed [MW-1:0]  fwd1_in,
  input  logic signed [MW-1:0]  bwd_in,
  input  logic signed [SYW-1:0] sys_in,
  input  logic signed [APW-1:0] apr_in,
  input  logic [QW-1:0]         q_shift,
  input  logic                  last_stage,
  output logic signed [MW+1:0]  llr_out,
  output logic                  hard_out,
  output logic signed [EW-1:0]  ext_out,
  output logic                  out_vld
);
  localparam int SW = MW + 1;
  localparam int LW = MW + 2;

  slot_pos_t            pos;
  logic signed [MW-1:0] fwd_a [2];
  logic signed [SW-1:0] max_a [2];
  logic                 bit_done;

  assign fwd_a[0] = fwd0_in;
  assign fwd_a[1] = fwd1_in;

  llr_slot_ctr #(.NSTATE(NSTATE)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_vld (slot_vld),
    .pos      (pos)
  );

  // One compare-select tracker per branch input value
  for (genvar g = 0; g < 2; g++) begin : g_track
    llr_max_track #(.MW(MW)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_vld   (slot_vld),
      .slot_first (pos.first),
      .fwd        (fwd_a[g]),
      .bwd        (bwd_in),
      .cur_max    (max_a[g])
    );
  end

  assign bit_done = slot_vld & pos.last;

  llr_bit_finish #(
    .SW(SW), .SYW(SYW), .APW(APW), .QW(QW), .EW(EW)
  ) u_fin (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_done   (bit_done),
    .max0       (max_a[0]),
    .max1       (max_a[1]),
    .sys_in     (sys_in),
    .apr_in     (apr_in),
    .q_shift    (q_shift),
    .last_stage (last_stage),
    .llr_q      (llr_out),
    .hard_q     (hard_out),
    .ext_q      (ext_out),
    .vld_q      (out_vld)
  );
endmodule

// File: rtl/maxlog_llr_serial_chk.sv
module maxlog_llr_serial_chk #(
  parameter int NSTATE = 16,
  parameter int LW     = 12,
  parameter int EW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 slot_vld,
  input logic                 last_stage,
  input logic signed [LW-1:0] llr_out,
  input logic                 hard_out,
  input logic signed [EW-1:0] ext_out,
  input logic                 out_vld
);
  localparam int CW = $clog2(NSTATE);
  logic [CW-1:0] seen_q;

  // Independent count of state slots within the current bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (slot_vld) seen_q <= (seen_q == CW'(NSTATE - 1)) ? '0 : seen_q + 1'b1;
  end

  // R7
  vld_after_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(slot_vld && (seen_q == CW'(NSTATE - 1))));

  // R7
  vld_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R7
  hold_between_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(llr_out) && $stable(ext_out) && $stable(hard_out)));

  // R4
  hard_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (hard_out == (llr_out < 0)));

  // R6
  last_stage_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(last_stage)) |-> (ext_out == '0));

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!out_vld && llr_out == '0 && ext_out == '0 && !hard_out);
    end
  end
endmodule

bind maxlog_llr_serial maxlog_llr_serial_chk #(
  .NSTATE(NSTATE), .LW(LW), .EW(EW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_vld   (slot_vld),
  .last_stage (last_stage),
  .llr_out    (llr_out),
  .hard_out   (hard_out),
  .ext_out    (ext_out),
  .out_vld    (out_vld)
);

// File: tb/maxlog_llr_serial_bench.sv
module maxlog_llr_serial_bench;
  localparam int NSTATE = 16;
  localparam int MW = 10, SYW = 6, APW = 8, QW = 2, EW = 8;
  localparam int LW = MW + 2;
  localparam time TCK = 20ns;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  slot_vld;
  logic signed [MW-1:0]  fwd0_in, fwd1_in, bwd_in;
  logic signed [SYW-1:0] sys_in;
  logic signed [APW-1:0] apr_in;
  logic [QW-1:0]         q_shift;
  logic                  last_stage;
  logic signed [LW-1:0]  llr_out;
  logic                  hard_out;
  logic signed [EW-1:0]  ext_out;
  logic                  out_vld;

  always #(TCK/2) clk = ~clk;

  maxlog_llr_serial u_maxlog_llr_serial (
    .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld),
    .fwd0_in(fwd0_in), .fwd1_in(fwd1_in), .bwd_in(bwd_in),
    .sys_in(sys_in), .apr_in(apr_in), .q_shift(q_shift),
    .last_stage(last_stage), .llr_out(llr_out), .hard_out(hard_out),
    .ext_out(ext_out), .out_vld(out_vld)
  );

  typedef struct { int llr; bit hard; int ext; bit last; } exp_t;
  exp_t sbq[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;
  int a0 [NSTATE];
  int a1 [NSTATE];
  int bb [NSTATE];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int s, input int i, input int k);
    return ((s * 131 + i * 97 + k * 53 + 7) * 7919) % 1023 - 511;
  endfunction

  task automatic fill_gen(input int seed);
    for (int i = 0; i < NSTATE; i++) begin
      a0[i] = gen(seed, i, 0);
      a1[i] = gen(seed, i, 1);
      bb[i] = gen(seed, i, 2);
    end
  endtask

  // Driver: computes the expected result from the requirements, queues it,
  // then plays the slots (with optional idle gaps carrying decoy metrics)
  task automatic run_bit(input int sys, input int apr, input int q,
                         input bit last, input int gap);
    exp_t e;
    int m0, m1, x;
    m0 = a0[0] + bb[0];
    m1 = a1[0] + bb[0];
    for (int i = 1; i < NSTATE; i++) begin
      if (a0[i] + bb[i] > m0) m0 = a0[i] + bb[i];
      if (a1[i] + bb[i] > m1) m1 = a1[i] + bb[i];
    end
    e.llr  = m0 - m1;
    e.hard = (e.llr < 0);
    x = e.llr - 2 * sys - 2 * (apr >>> q);
    if (x > 127)  x = 127;
    if (x < -128) x = -128;
    e.ext  = last ? 0 : x;
    e.last = last;
    sbq.push_back(e);
    for (int i = 0; i < NSTATE; i++) begin
      if (gap > 0 && (i % 4) == 2) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          slot_vld = 1'b0;
          fwd0_in = (i % 8 == 2) ? 10'sd511 : -10'sd512;
          fwd1_in = (i % 8 == 2) ? -10'sd512 : 10'sd511;
          bwd_in  = 10'sd511;
          sys_in  = 6'sd31;
          apr_in  = -8'sd128;
        end
      end
      @(negedge clk);
      slot_vld   = 1'b1;
      fwd0_in    = MW'(a0[i]);
      fwd1_in    = MW'(a1[i]);
      bwd_in     = MW'(bb[i]);
      sys_in     = SYW'(sys);
      apr_in     = APW'(apr);
      q_shift    = QW'(q);
      last_stage = last;
    end
    @(negedge clk);
    slot_vld = 1'b0;
  endtask

  // Monitor: pops one expected item per output pulse
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R7 unexpected out_vld", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(int'(llr_out) == e.llr, "R1/R2/R3 llr", int'(llr_out), e.llr);
        chk(hard_out == e.hard, "R4 hard", int'(hard_out), int'(e.hard));
        chk(int'(ext_out) == e.ext, e.last ? "R6 ext last stage" : "R5 ext",
            int'(ext_out), e.ext);
      end
    end
  end

  initial begin
    rst_n = 1'b0; slot_vld = 1'b0;
    fwd0_in = '0; fwd1_in = '0; bwd_in = '0;
    sys_in = '0; apr_in = '0; q_shift = '0; last_stage = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_vld == 1'b0, "R8 out_vld in reset", int'(out_vld), 0);
    chk(llr_out == '0, "R8 llr in reset", int'(llr_out), 0);
    chk(ext_out == '0 && hard_out == 1'b0, "R8 ext/hard in reset", int'(ext_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill_gen(1);
    run_bit(5, -20, 2, 1'b0, 0);

    // Equal branch metrics: LLR 0, hard 0 (R4 boundary)
    for (int i = 0; i < NSTATE; i++) begin
      a0[i] = 100; a1[i] = 100; bb[i] = gen(3, i, 2);
    end
    run_bit(0, 0, 0, 1'b0, 0);
    run_bit(3, 9, 1, 1'b0, 0);

    // Negative saturation (R5)
    for (int i = 0; i < NSTATE; i++) begin
      a0[i] = -512; a1[i] = 511; bb[i] = 511 - i;
    end
    run_bit(0, 0, 0, 1'b0, 0);

    // Positive saturation; small bit follows large one (R3)
    for (int i = 0; i < NSTATE; i++) begin
      a0[i] = 511; a1[i] = -512; bb[i] = -512 + i;
    end
    run_bit(-32, 127, 0, 1'b0, 0);
    for (int i = 0; i < NSTATE; i++) begin
      a0[i] = -300 + i; a1[i] = -290 - i; bb[i] = -200;
    end
    run_bit(2, -9, 3, 1'b0, 0);

    // Last stage (R6)
    fill_gen(7);
    run_bit(10, 40, 1, 1'b1, 0);

    // Gapped strobe with decoy metrics (R2)
    fill_gen(9);
    run_bit(-4, 17, 2, 1'b0, 3);
    fill_gen(11);
    run_bit(6, -33, 0, 1'b0, 1);

    for (int s = 12; s < 32; s++) begin
      fill_gen(s);
      run_bit((s * 5) % 60 - 30, (s * 37) % 250 - 125, s % 4, (s % 7) == 0, s % 3);
    end

    repeat (4) @(negedge clk);
    // R7: every expected result was produced
    chk(sbq.size() == 0, "R7 missing out_vld", sbq.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule